// File: doc/BRIEF.md
# Epoch-Tagged Pipeline Flush Controller

This block models the control backbone of a six-stage in-order pipeline: fetch, decode, operand read, execute, memory and writeback. Tokens enter at fetch through a valid/ready handshake. Each token carries an identifier and an exception flag. The tokens move one stage per cycle while the next stage can take them. A token that reaches writeback without a trap flag retires through a second valid/ready handshake.

Interrupt requests are sampled while a token leaves decode, and the request is attached to that token. Exceptions and interrupts are both acted on only at writeback. Taking a trap does not clear the stage registers. Each stage keeps a one-bit epoch register, and taking a trap toggles all of them in the same cycle. Every in-flight token still carries the old epoch, so each stage treats it as empty and drops it. The trap cycle produces a single-cycle trap pulse, the identifier of the trapping token, and a redirect address chosen by the trap cause.

Top module: `epoch_pipe`

## Requirements
- R1: After reset, and after a reset applied while tokens are in flight, `ret_valid` and `trap_pulse` are 0, `in_ready` is 1, and no token accepted before that reset ever retires.
- R2: Tokens without a trap flag retire in the order they were accepted. With no backpressure, a token accepted in cycle c shows `ret_valid` in cycle c+6.
- R3: A token that reaches writeback with its exception flag set raises `trap_pulse` for one cycle. In that cycle `trap_tag` equals the token's identifier and `redirect_addr` equals `EXC_VEC`. The token never retires.
- R4: If `irq_req` is 1 in the cycle a token moves from decode onward, that token traps at writeback with `trap_irq` = 1 and `redirect_addr` = `IRQ_VEC`.
- R5: A token that carries both an exception and an attached interrupt traps as an exception: `trap_irq` = 0 and `redirect_addr` = `EXC_VEC`.
- R6: Every token that is younger than a taken trap and was accepted before the trap cycle is discarded. It neither retires nor traps, even if it has its own exception flag.
- R7: `in_ready` is 0 in the trap cycle. Tokens accepted from the next cycle on carry the new epoch and retire normally.
- R8: A stage that cannot pass its token on holds the token. With `ret_ready` held at 0, exactly six tokens are accepted, and `ret_tag` stays on the oldest one while `ret_valid` stays 1.
- R9: A trap commits at writeback whatever the value of `ret_ready`.
- R10: `trap_pulse` never stays high for two cycles in a row, and `ret_valid` is 0 in the cycle after a trap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A new token is offered to fetch |
| in_ready | output | 1 | Fetch takes the offered token at this edge |
| in_tag | input | TAG_W | Identifier of the offered token |
| in_exc | input | 1 | The offered token raises an exception |
| irq_req | input | 1 | Interrupt request level, sampled when a token leaves decode |
| ret_ready | input | 1 | The consumer takes the retiring token |
| ret_valid | output | 1 | A token without a trap flag is ready to retire |
| ret_tag | output | TAG_W | Identifier of the retiring token |
| trap_pulse | output | 1 | A trap commits in this cycle |
| trap_irq | output | 1 | The committing trap is an interrupt (1) or an exception (0) |
| trap_tag | output | TAG_W | Identifier of the trapping token |
| redirect_addr | output | ADDR_W | Address fetch restarts from after the trap |

## Verification
The assertions assume that reset lasts at least one edge, that the pipeline has at least three stages, and that the consumer may drop `ret_ready` at any time. They do not depend on the identifier values. To keep the offered pattern within reach of a reference model, the stimulus gives each token a unique, increasing identifier. It raises `irq_req` for exactly one cycle, in the cycle a known token leaves decode, and only while no stage is stalled. Each dropped or retired token can then be traced back to the cycle in which it was accepted.

// File: rtl/epoch_pipe_pkg.sv
package epoch_pipe_pkg;

    // Control fields carried beside every token identifier
    typedef struct packed {
        logic epoch;
        logic exc;
        logic irq;
    } tok_meta_t;

    typedef enum logic [1:0] {
        CAUSE_NONE = 2'd0,
        CAUSE_EXC  = 2'd1,
        CAUSE_IRQ  = 2'd2
    } trap_cause_e;

    // Synchronous exception outranks an attached interrupt
    function automatic trap_cause_e cause_of(tok_meta_t m);
        if (m.exc) return CAUSE_EXC;
        if (m.irq) return CAUSE_IRQ;
        return CAUSE_NONE;
    endfunction

    function automatic tok_meta_t stamp_epoch(tok_meta_t m, logic ep);
        tok_meta_t r;
        r = m;
        r.epoch = ep;
        return r;
    endfunction

    function automatic tok_meta_t attach_irq(tok_meta_t m, logic req);
        tok_meta_t r;
        r = m;
        r.irq = m.irq | req;
        return r;
    endfunction

endpackage

// File: rtl/epoch_stage.sv
module epoch_stage
    import epoch_pipe_pkg::*;
#(
    parameter int TAG_W = 8,
    parameter bit STAMP = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             up_valid,
    input  logic [TAG_W-1:0] up_tag,
    input  tok_meta_t        up_meta,
    output logic             up_ready,
    output logic             dn_valid,
    output logic [TAG_W-1:0] dn_tag,
    output tok_meta_t        dn_meta,
    input  logic             dn_ready,
    output logic             epoch
);

    logic             ep_q;
    logic             v_q;
    logic [TAG_W-1:0] tag_q;
    tok_meta_t        meta_q;
    logic             live;

    // A token whose tag disagrees with the local epoch counts as empty
    assign live     = v_q && (meta_q.epoch == ep_q);
    assign up_ready = !live || dn_ready;
    assign dn_valid = live;
    assign dn_tag   = tag_q;
    assign dn_meta  = meta_q;
    assign epoch    = ep_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ep_q   <= 1'b0;
            v_q    <= 1'b0;
            tag_q  <= '0;
            meta_q <= '0;
        end else begin
            ep_q <= ep_q ^ flush;
            if (up_ready) begin
                v_q    <= up_valid;
                tag_q  <= up_tag;
                meta_q <= STAMP ? stamp_epoch(up_meta, ep_q) : up_meta;
            end
        end
    end

    // R8: a live token blocked downstream is still held next cycle
    a_r8_stage_hold: assert property (@(posedge clk) disable iff (rst)
        live && !dn_ready |=> v_q && $stable(tag_q) && $stable(meta_q));

endmodule

// File: rtl/epoch_trap_unit.sv
module epoch_trap_unit
    import epoch_pipe_pkg::*;
#(
    parameter int          TAG_W   = 8,
    parameter int          ADDR_W  = 32,
    parameter logic [31:0] EXC_VEC = 32'h0000_0100,
    parameter logic [31:0] IRQ_VEC = 32'h0000_0200
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              w_valid,
    input  logic [TAG_W-1:0]  w_tag,
    input  tok_meta_t         w_meta,
    output logic              w_ready,
    input  logic              ret_ready,
    output logic              ret_valid,
    output logic [TAG_W-1:0]  ret_tag,
    output logic              flush,
    output logic              trap_irq,
    output logic [TAG_W-1:0]  trap_tag,
    output logic [ADDR_W-1:0] redirect_addr
);

    trap_cause_e cause;

    assign cause     = w_valid ? cause_of(w_meta) : CAUSE_NONE;
    assign flush     = (cause != CAUSE_NONE);
    assign trap_irq  = (cause == CAUSE_IRQ);
    assign trap_tag  = w_tag;
    assign ret_valid = w_valid && (cause == CAUSE_NONE);
    assign ret_tag   = w_tag;
    // A trapping token leaves through the epoch toggle, not the consumer
    assign w_ready   = flush || ret_ready;

    always_comb begin
        case (cause)
            CAUSE_EXC: redirect_addr = EXC_VEC[ADDR_W-1:0];
            CAUSE_IRQ: redirect_addr = IRQ_VEC[ADDR_W-1:0];
            default:   redirect_addr = '0;
        endcase
    end

    // R10: the cycle after a trap holds only stale tokens in writeback
    a_r10_single_pulse: assert property (@(posedge clk) disable iff (rst)
        flush |=> !flush);

endmodule

// File: rtl/epoch_pipe.sv
module epoch_pipe
    import epoch_pipe_pkg::*;
#(
    parameter int          TAG_W   = 8,
    parameter int          NSTAGE  = 6,
    parameter int          DEC_IDX = 1,
    parameter int          ADDR_W  = 32,
    parameter logic [31:0] EXC_VEC = 32'h0000_0100,
    parameter logic [31:0] IRQ_VEC = 32'h0000_0200
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [TAG_W-1:0]  in_tag,
    input  logic              in_exc,
    input  logic              irq_req,
    input  logic              ret_ready,
    output logic              ret_valid,
    output logic [TAG_W-1:0]  ret_tag,
    output logic              trap_pulse,
    output logic              trap_irq,
    output logic [TAG_W-1:0]  trap_tag,
    output logic [ADDR_W-1:0] redirect_addr
);

    localparam int MARK_LINK = DEC_IDX + 1;

    // Link i feeds stage i; link NSTAGE feeds the writeback trap unit
    logic             lnk_valid [NSTAGE+1];
    logic [TAG_W-1:0] lnk_tag   [NSTAGE+1];
    tok_meta_t        lnk_meta  [NSTAGE+1];
    logic             lnk_ready [NSTAGE+1];

    logic             st_valid [NSTAGE];
    logic [TAG_W-1:0] st_tag   [NSTAGE];
    tok_meta_t        st_meta  [NSTAGE];
    logic [NSTAGE-1:0] ep_vec;
    logic             flush;

    assign lnk_valid[0] = in_valid && !flush;
    assign lnk_tag[0]   = in_tag;
    assign lnk_meta[0]  = '{epoch: 1'b0, exc: in_exc, irq: 1'b0};
    assign in_ready     = lnk_ready[0] && !flush;
    assign trap_pulse   = flush;

    for (genvar i = 0; i < NSTAGE; i++) begin : g_stage
        epoch_stage #(
            .TAG_W (TAG_W),
            .STAMP (i == 0)
        ) u_stage (
            .clk      (clk),
            .rst      (rst),
            .flush    (flush),
            .up_valid (lnk_valid[i]),
            .up_tag   (lnk_tag[i]),
            .up_meta  (lnk_meta[i]),
            .up_ready (lnk_ready[i]),
            .dn_valid (st_valid[i]),
            .dn_tag   (st_tag[i]),
            .dn_meta  (st_meta[i]),
            .dn_ready (lnk_ready[i+1]),
            .epoch    (ep_vec[i])
        );
    end

    for (genvar i = 1; i <= NSTAGE; i++) begin : g_link
        assign lnk_valid[i] = st_valid[i-1];
        assign lnk_tag[i]   = st_tag[i-1];
        if (i == MARK_LINK) begin : g_mark
            // Interrupt is attached to the token leaving decode
            assign lnk_meta[i] = attach_irq(st_meta[i-1], irq_req);
        end else begin : g_pass
            assign lnk_meta[i] = st_meta[i-1];
        end
    end

    epoch_trap_unit #(
        .TAG_W   (TAG_W),
        .ADDR_W  (ADDR_W),
        .EXC_VEC (EXC_VEC),
        .IRQ_VEC (IRQ_VEC)
    ) u_trap (
        .clk           (clk),
        .rst           (rst),
        .w_valid       (lnk_valid[NSTAGE]),
        .w_tag         (lnk_tag[NSTAGE]),
        .w_meta        (lnk_meta[NSTAGE]),
        .w_ready       (lnk_ready[NSTAGE]),
        .ret_ready     (ret_ready),
        .ret_valid     (ret_valid),
        .ret_tag       (ret_tag),
        .flush         (flush),
        .trap_irq      (trap_irq),
        .trap_tag      (trap_tag),
        .redirect_addr (redirect_addr)
    );

    // R6: separately held epoch registers never disagree
    a_r6_epochs_agree: assert property (@(posedge clk) disable iff (rst)
        (ep_vec == '0) || (ep_vec == '1));

    // R10: nothing stale retires right after a trap
    a_r10_quiet_after_trap: assert property (@(posedge clk) disable iff (rst)
        trap_pulse |=> !ret_valid);

    // R8: an unaccepted retirement is held unchanged
    a_r8_ret_hold: assert property (@(posedge clk) disable iff (rst)
        ret_valid && !ret_ready |=> ret_valid && $stable(ret_tag));

endmodule

// File: tb/epoch_pipe_test.sv
`timescale 1ns/1ps
module epoch_pipe_test;

    localparam int          TAG_W   = 8;
    localparam int          ADDR_W  = 32;
    localparam logic [31:0] EXC_VEC = 32'h0000_0100;
    localparam logic [31:0] IRQ_VEC = 32'h0000_0200;
    localparam int          LAT     = 6;
    localparam int          NVEC    = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0, in_exc = 1'b0, irq_req = 1'b0, ret_ready = 1'b1;
    logic [TAG_W-1:0] in_tag = '0;
    logic in_ready, ret_valid, trap_pulse, trap_irq;
    logic [TAG_W-1:0] ret_tag, trap_tag;
    logic [ADDR_W-1:0] redirect_addr;

    epoch_pipe #(
        .TAG_W(TAG_W), .NSTAGE(6), .DEC_IDX(1), .ADDR_W(ADDR_W),
        .EXC_VEC(EXC_VEC), .IRQ_VEC(IRQ_VEC)
    ) uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_tag(in_tag), .in_exc(in_exc), .irq_req(irq_req),
        .ret_ready(ret_ready), .ret_valid(ret_valid), .ret_tag(ret_tag),
        .trap_pulse(trap_pulse), .trap_irq(trap_irq), .trap_tag(trap_tag),
        .redirect_addr(redirect_addr)
    );

    always #2.5 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int nchk = 0, nfail = 0, seq = 0, last_ret = -1;
    int acc_cyc [256];
    int ret_cyc [256];
    int trap_cyc [256];
    bit exc_of [256];
    bit trap_irq_of [256];

    // {count, exc index A, exc index B, irq index, stall, expected traps}; 255 = unused
    localparam logic [40:0] VEC [NVEC] = '{
        {8'd10, 8'd255, 8'd255, 8'd255, 1'b0, 8'd0},
        {8'd20, 8'd7,   8'd255, 8'd255, 1'b0, 8'd1},
        {8'd20, 8'd5,   8'd8,   8'd255, 1'b0, 8'd1},
        {8'd30, 8'd4,   8'd15,  8'd255, 1'b0, 8'd2},
        {8'd20, 8'd6,   8'd255, 8'd255, 1'b1, 8'd1},
        {8'd16, 8'd255, 8'd255, 8'd5,   1'b0, 8'd1},
        {8'd24, 8'd3,   8'd255, 8'd255, 1'b1, 8'd1},
        {8'd12, 8'd0,   8'd255, 8'd255, 1'b0, 8'd1},
        {8'd12, 8'd11,  8'd255, 8'd255, 1'b0, 8'd1},
        {8'd16, 8'd5,   8'd255, 8'd5,   1'b0, 8'd1}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic sample_outputs(inout int traps);
        if (ret_valid && ret_ready) begin
            chk(int'(ret_tag) > last_ret, "R2 in-order retire", int'(ret_tag), last_ret + 1);
            ret_cyc[ret_tag] = cyc;
            last_ret = int'(ret_tag);
        end
        if (trap_pulse) begin
            traps++;
            trap_cyc[trap_tag]    = cyc;
            trap_irq_of[trap_tag] = trap_irq;
            chk(!in_ready, "R7 no accept in trap cycle", int'(in_ready), 0);
            chk(!ret_valid, "R3 trapping token not retired", int'(ret_valid), 0);
            chk(redirect_addr == (exc_of[trap_tag] ? EXC_VEC : IRQ_VEC),
                "R3/R4/R5 redirect", int'(redirect_addr),
                int'(exc_of[trap_tag] ? EXC_VEC : IRQ_VEC));
        end
    endtask

    task automatic run_vector(input logic [40:0] v);
        int n, ea, eb, iq, ex, base, idx, drain, traps, last_trap;
        bit st;
        n = int'(v[40:33]); ea = int'(v[32:25]); eb = int'(v[24:17]);
        iq = int'(v[16:9]); st = v[8]; ex = int'(v[7:0]);
        base = seq; idx = 0; drain = 0; traps = 0;
        while (idx < n || drain < 20) begin
            @(negedge clk);
            ret_ready = st ? ((cyc % 2) == 1) : 1'b1;
            in_valid  = (idx < n);
            in_tag    = TAG_W'(base + idx);
            in_exc    = (idx < n) && (idx == ea || idx == eb);
            irq_req   = (iq != 255) && (idx < n) && (idx == iq + 2);
            #1;
            sample_outputs(traps);
            if (in_valid && in_ready) begin
                acc_cyc[base + idx] = cyc;
                exc_of[base + idx]  = in_exc;
                idx++;
            end else if (idx >= n) begin
                drain++;
            end
        end
        in_valid = 1'b0; in_exc = 1'b0; irq_req = 1'b0;
        seq = base + n;
        // Reference: walk the tokens oldest first
        last_trap = -1;
        for (int t = base; t < base + n; t++) begin
            if (last_trap >= 0 && acc_cyc[t] < last_trap) begin
                chk(ret_cyc[t] < 0 && trap_cyc[t] < 0, "R6 younger token discarded",
                    ret_cyc[t], -1);
            end else if (exc_of[t] || (t - base == iq)) begin
                chk(trap_cyc[t] >= 0 && ret_cyc[t] < 0, "R3/R4 token traps", trap_cyc[t], 0);
                chk(trap_irq_of[t] == !exc_of[t], "R4/R5 trap cause",
                    int'(trap_irq_of[t]), int'(!exc_of[t]));
                last_trap = trap_cyc[t];
            end else begin
                chk(ret_cyc[t] >= 0, "R2/R7 token retires", ret_cyc[t], 0);
            end
        end
        chk(traps == ex, "R6 trap count", traps, ex);
        if (!st && ea != 0)
            chk(ret_cyc[base] == acc_cyc[base] + LAT, "R2 latency",
                ret_cyc[base] - acc_cyc[base], LAT);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) begin
            acc_cyc[i] = -1; ret_cyc[i] = -1; trap_cyc[i] = -1;
            exc_of[i] = 1'b0; trap_irq_of[i] = 1'b0;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1: reset state
        chk(!ret_valid, "R1 ret_valid after reset", int'(ret_valid), 0);
        chk(!trap_pulse, "R1 trap_pulse after reset", int'(trap_pulse), 0);
        chk(in_ready, "R1 in_ready after reset", int'(in_ready), 1);

        for (int k = 0; k < NVEC; k++) run_vector(VEC[k]);

        // R8: hold under backpressure, exactly six tokens fit
        begin
            int acc, base, got, dummy;
            base = seq; acc = 0; got = 0; dummy = 0;
            for (int c = 0; c < 14; c++) begin
                @(negedge clk);
                ret_ready = 1'b0; in_valid = 1'b1; in_exc = 1'b0;
                in_tag = TAG_W'(base + acc);
                #1;
                if (ret_valid)
                    chk(int'(ret_tag) == base, "R8 ret_tag held", int'(ret_tag), base);
                if (in_valid && in_ready) acc++;
            end
            chk(acc == 6, "R8 six tokens held", acc, 6);
            chk(ret_valid, "R8 ret_valid held", int'(ret_valid), 1);
            for (int c = 0; c < 12; c++) begin
                @(negedge clk);
                in_valid = 1'b0; ret_ready = 1'b1;
                #1;
                if (ret_valid) begin
                    chk(int'(ret_tag) == base + got, "R8 release order", int'(ret_tag), base + got);
                    got++;
                end
                sample_outputs(dummy);
            end
            chk(got == 6, "R8 all held tokens retire", got, 6);
            seq = base + 6;
        end

        // R9: trap commits while the consumer refuses
        begin
            int seen, base;
            base = seq; seen = 0;
            @(negedge clk);
            ret_ready = 1'b0; in_valid = 1'b1; in_exc = 1'b1; in_tag = TAG_W'(base);
            #1;
            exc_of[base] = 1'b1;
            for (int c = 0; c < 10; c++) begin
                @(negedge clk);
                in_valid = 1'b0; in_exc = 1'b0;
                #1;
                if (trap_pulse) begin
                    seen++;
                    chk(int'(trap_tag) == base, "R9 trap tag", int'(trap_tag), base);
                end
                chk(!ret_valid, "R9 no retire", int'(ret_valid), 0);
            end
            chk(seen == 1, "R9 trap taken with ret_ready low", seen, 1);
            seq = base + 1;
        end

        // R1: reset while tokens are in flight
        begin
            int bad;
            bad = 0;
            for (int c = 0; c < 3; c++) begin
                @(negedge clk);
                ret_ready = 1'b1; in_valid = 1'b1; in_exc = 1'b0; in_tag = TAG_W'(seq + c);
            end
            @(negedge clk);
            in_valid = 1'b0; rst = 1'b1;
            repeat (2) @(negedge clk);
            rst = 1'b0;
            #1;
            chk(in_ready, "R1 in_ready after mid-flight reset", int'(in_ready), 1);
            for (int c = 0; c < 12; c++) begin
                @(negedge clk);
                #1;
                if (ret_valid || trap_pulse) bad++;
            end
            chk(bad == 0, "R1 flushed by reset", bad, 0);
        end

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        nchk++; nfail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule